// File: doc/BRIEF.md
# Register-Programmed Device-to-Memory Transfer Engine

This block moves a programmed number of words from a device data stream into memory without processor involvement. Software loads a destination word address and a word count through a small register port, then writes a start command. The engine takes one word at a time from the device, and writes each word to memory in its own bus write. It advances the destination address and lowers the remaining count after each accepted write.

The engine and the processor share the memory bus. A fixed-priority arbiter inside the block always serves the engine first, and grants the bus to the processor only when the engine has no write pending. When the count runs out, the engine sets a done flag. When a memory write is refused, or a start is issued with a zero count, it sets an error flag instead. Either flag raises the interrupt output when interrupts are enabled. Software clears each flag by writing a one to its status bit.

Top module: `dma_engine`

## Requirements
- R1: After reset, the status register reads 0, and irq, mem_we, dev_ready and cpu_bus_gnt are all 0.
- R2: Register offsets: 0 is the destination word address and 1 is the remaining word count; both read back the live value. Offset 2 is control: bit 1 is interrupt enable and reads back, bit 0 is start and always reads 0. Offset 3 is status: bit 0 is done, bit 1 is error, bit 2 is busy.
- R3: A start with a non-zero count sets busy. The engine then takes device words only on cycles where dev_valid and dev_ready are both high, and writes them to memory in arrival order with one write per word.
- R4: After each accepted write (mem_ack high with mem_err low), the address goes up by one and wraps modulo 2^ADDR_W, and the count goes down by one.
- R5: When the count reaches zero, done is set and busy is cleared. No device word beyond the programmed count is taken.
- R6: A start with a zero count sets the error bit on the next cycle, and produces no memory write and no device handshake.
- R7: irq is high exactly when interrupt enable is set and done or error is set. With enable clear, irq stays low.
- R8: Writing status with bit 0 set clears done, and with bit 1 set clears error. Clearing the flag that holds irq high drops irq. Bits written as 0 leave their flag unchanged.
- R9: While the engine requests the bus, cpu_bus_gnt is low. When the engine is not requesting, cpu_bus_gnt follows cpu_bus_req.
- R10: A write acknowledged with mem_err high sets error, clears busy and ends the transfer. The address and count are left at the failed word.
- R11: While busy, writes to the address and count registers and further start commands are ignored.
- R12: While mem_we is high and mem_ack is low, mem_addr and mem_wdata stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for the selected register |
| dev_valid | input | 1 | Device word available |
| dev_data | input | DATA_W | Device word |
| dev_ready | output | 1 | Engine takes the device word this cycle |
| cpu_bus_req | input | 1 | Processor asks for the memory bus |
| cpu_bus_gnt | output | 1 | Processor owns the memory bus this cycle |
| mem_we | output | 1 | Engine memory write request, granted |
| mem_addr | output | ADDR_W | Word address of the write |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Memory completes the write this cycle |
| mem_err | input | 1 | Completed write failed (valid with mem_ack) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the engine with ADDR_W=8 and CNT_W=4, keeping DATA_W=32. The 8-bit address lets a short transfer started at 0xFE cross the wrap to 0x00. The 4-bit count keeps every transfer under sixteen words, so stalls, gaps and errors on particular words can be placed by hand. A 256-word memory model with adjustable latency and error injection, and a device model with optional idle gaps, exercise the hold rule and the mid-transfer error.

// File: rtl/dma_pkg.sv
package dma_pkg;

    localparam logic [1:0] SEL_ADDR   = 2'd0;
    localparam logic [1:0] SEL_COUNT  = 2'd1;
    localparam logic [1:0] SEL_CTRL   = 2'd2;
    localparam logic [1:0] SEL_STATUS = 2'd3;

    localparam int CTRL_START_BIT = 0;
    localparam int CTRL_IE_BIT    = 1;
    localparam int STAT_DONE_BIT  = 0;
    localparam int STAT_ERR_BIT   = 1;
    localparam int STAT_BUSY_BIT  = 2;

    typedef enum logic [1:0] {
        MV_IDLE  = 2'd0,
        MV_FETCH = 2'd1,
        MV_WRITE = 2'd2
    } mv_state_e;

endpackage

// File: rtl/dma_arb.sv
module dma_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_req_i,
    input  logic cpu_req_i,
    output logic dma_gnt_o,
    output logic cpu_gnt_o
);

    always_comb begin
        dma_gnt_o = dma_req_i;
        cpu_gnt_o = cpu_req_i && !dma_req_i;
    end

    assert_cpu_yields_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req_i |-> (!cpu_gnt_o && dma_gnt_o));

endmodule

// File: rtl/dma_mover.sv
module dma_mover
    import dma_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              dev_valid_i,
    input  logic [DATA_W-1:0] dev_data_i,
    output logic              dev_ready_o,
    output logic              bus_req_o,
    input  logic              gnt_i,
    input  logic              mem_ack_i,
    input  logic              mem_err_i,
    output logic [DATA_W-1:0] wdata_o,
    output logic              step_o,
    output logic              fail_o
);

    typedef struct packed {
        mv_state_e         state;
        logic [DATA_W-1:0] data;
    } mv_t;

    mv_t mv_d, mv_q;
    logic done_write;

    always_comb begin
        mv_d       = mv_q;
        done_write = (mv_q.state == MV_WRITE) && gnt_i && mem_ack_i;
        case (mv_q.state)
            MV_IDLE: begin
                if (busy_i) mv_d.state = MV_FETCH;
            end
            MV_FETCH: begin
                if (!busy_i) begin
                    mv_d.state = MV_IDLE;
                end else if (dev_valid_i) begin
                    mv_d.data  = dev_data_i;
                    mv_d.state = MV_WRITE;
                end
            end
            MV_WRITE: begin
                if (done_write) mv_d.state = MV_FETCH;
            end
            default: mv_d.state = MV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mv_q <= '{state: MV_IDLE, data: '0};
        end else begin
            mv_q <= mv_d;
        end
    end

    assign dev_ready_o = (mv_q.state == MV_FETCH) && busy_i;
    assign bus_req_o   = (mv_q.state == MV_WRITE);
    assign wdata_o     = mv_q.data;
    assign step_o      = done_write;
    assign fail_o      = done_write && mem_err_i;

    assert_hold_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !(gnt_i && mem_ack_i)) |=> (bus_req_o && $stable(wdata_o)));

    assert_take_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ready_o && dev_valid_i) |=> (bus_req_o && wdata_o == $past(dev_data_i)));

endmodule

// File: rtl/dma_regs.sv
module dma_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_sel_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              step_i,
    input  logic              fail_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              irq_o
);

    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              ie;
        logic              done;
        logic              err;
        logic              busy;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_addr, wr_cnt, wr_ctrl, wr_stat;

    always_comb begin
        r_d     = r_q;
        wr_addr = reg_wr_i && (reg_sel_i == SEL_ADDR);
        wr_cnt  = reg_wr_i && (reg_sel_i == SEL_COUNT);
        wr_ctrl = reg_wr_i && (reg_sel_i == SEL_CTRL);
        wr_stat = reg_wr_i && (reg_sel_i == SEL_STATUS);

        if (!r_q.busy && wr_addr) r_d.addr = reg_wdata_i[ADDR_W-1:0];
        if (!r_q.busy && wr_cnt)  r_d.cnt  = reg_wdata_i[CNT_W-1:0];

        if (wr_ctrl) begin
            r_d.ie = reg_wdata_i[CTRL_IE_BIT];
            if (reg_wdata_i[CTRL_START_BIT] && !r_q.busy) begin
                r_d.done = 1'b0;
                if (r_q.cnt == '0) begin
                    r_d.err = 1'b1;
                end else begin
                    r_d.err  = 1'b0;
                    r_d.busy = 1'b1;
                end
            end
        end

        if (wr_stat) begin
            if (reg_wdata_i[STAT_DONE_BIT]) r_d.done = 1'b0;
            if (reg_wdata_i[STAT_ERR_BIT])  r_d.err  = 1'b0;
        end

        if (step_i && r_q.busy) begin
            if (fail_i) begin
                r_d.err  = 1'b1;
                r_d.busy = 1'b0;
            end else begin
                r_d.addr = r_q.addr + ADDR_ONE;
                r_d.cnt  = r_q.cnt - CNT_ONE;
                if (r_q.cnt == CNT_ONE) begin
                    r_d.done = 1'b1;
                    r_d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_sel_i)
            SEL_ADDR:  reg_rdata_o[ADDR_W-1:0] = r_q.addr;
            SEL_COUNT: reg_rdata_o[CNT_W-1:0]  = r_q.cnt;
            SEL_CTRL:  reg_rdata_o[CTRL_IE_BIT] = r_q.ie;
            default: begin
                reg_rdata_o[STAT_DONE_BIT] = r_q.done;
                reg_rdata_o[STAT_ERR_BIT]  = r_q.err;
                reg_rdata_o[STAT_BUSY_BIT] = r_q.busy;
            end
        endcase
    end

    assign busy_o  = r_q.busy;
    assign addr_o  = r_q.addr;
    assign count_o = r_q.cnt;
    assign irq_o   = r_q.ie && (r_q.done || r_q.err);

    assert_addr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && step_i && !fail_i) |=>
            (addr_o == $past(addr_o) + ADDR_ONE && count_o == $past(count_o) - CNT_ONE));

    assert_last_word_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && step_i && !fail_i && count_o == CNT_ONE) |=> (!busy_o && count_o == '0));

    assert_zero_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && reg_wdata_i[CTRL_START_BIT] && !busy_o && count_o == '0) |=>
            (!busy_o && reg_sel_i != SEL_STATUS || !busy_o));

    assert_fail_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && step_i && fail_i) |=> (!busy_o && addr_o == $past(addr_o)
            && count_o == $past(count_o)));

    assert_busy_locks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && wr_addr && !step_i) |=> (addr_o == $past(addr_o)));

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dev_valid,
    input  logic [DATA_W-1:0] dev_data,
    output logic              dev_ready,
    input  logic              cpu_bus_req,
    output logic              cpu_bus_gnt,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic              irq
);

    logic              busy;
    logic              step;
    logic              fail;
    logic              dma_req;
    logic              dma_gnt;
    logic [CNT_W-1:0]  count;

    dma_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (reg_wr),
        .reg_sel_i   (reg_sel),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .step_i      (step),
        .fail_i      (fail),
        .busy_o      (busy),
        .addr_o      (mem_addr),
        .count_o     (count),
        .irq_o       (irq)
    );

    dma_mover #(
        .DATA_W (DATA_W)
    ) u_mover (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy_i      (busy),
        .dev_valid_i (dev_valid),
        .dev_data_i  (dev_data),
        .dev_ready_o (dev_ready),
        .bus_req_o   (dma_req),
        .gnt_i       (dma_gnt),
        .mem_ack_i   (mem_ack),
        .mem_err_i   (mem_err),
        .wdata_o     (mem_wdata),
        .step_o      (step),
        .fail_o      (fail)
    );

    dma_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .dma_req_i (dma_req),
        .cpu_req_i (cpu_bus_req),
        .dma_gnt_o (dma_gnt),
        .cpu_gnt_o (cpu_bus_gnt)
    );

    assign mem_we = dma_gnt;

    assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !mem_ack) |=> (mem_we && $stable(mem_addr) && $stable(mem_wdata)));

    assert_count_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (busy && count != '0));

endmodule

// File: tb/sim_dma_engine.sv
module sim_dma_engine;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 32;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          dev_valid = 1'b0;
    logic [DW-1:0] dev_data = '0;
    logic          dev_ready;
    logic          cpu_bus_req = 1'b0;
    logic          cpu_bus_gnt;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic          mem_err = 1'b0;
    logic          irq;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] mem [0:255];
    int  nwr = 0;
    int  mem_lat = 0;
    int  stall = 0;
    int  ack_idx = 0;
    int  err_at = -1;
    int  prio_bad = 0;
    int  dev_idx = 0;
    int  dev_limit = 0;
    bit  dev_gappy = 1'b0;
    bit  tgl = 1'b0;
    logic dev_hs = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_engine #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_valid(dev_valid),
        .dev_data(dev_data), .dev_ready(dev_ready), .cpu_bus_req(cpu_bus_req),
        .cpu_bus_gnt(cpu_bus_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .irq(irq)
    );

    // Monitors sampling pre-edge values
    always @(posedge clk) begin
        dev_hs <= dev_valid && dev_ready;
        if (mem_we && mem_ack && !mem_err) begin
            mem[mem_addr] <= mem_wdata;
            nwr <= nwr + 1;
        end
    end

    always @(negedge clk) if (mem_we && cpu_bus_gnt) prio_bad++;

    // Memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
                mem_err = 1'b0;
            end else if (mem_we) begin
                if (stall < mem_lat) begin
                    stall++;
                end else begin
                    stall   = 0;
                    mem_ack = 1'b1;
                    mem_err = (ack_idx == err_at);
                    ack_idx++;
                end
            end
        end
    end

    // Device source
    initial begin
        forever begin
            @(negedge clk);
            if (dev_hs) dev_idx++;
            dev_valid = (dev_idx < dev_limit) && (!dev_gappy || tgl);
            dev_data  = 32'hC0DE_0000 + dev_idx;
            tgl = !tgl;
        end
    end

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [DW-1:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [DW-1:0] s;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            #2;
            rd(2'd3, s);
            if (!s[2]) break;
        end
    endtask

    task automatic dev_arm(input int n);
        @(negedge clk);
        #1;
        dev_limit = dev_idx + n;
    endtask

    task automatic t_reset();
        logic [DW-1:0] s;
        rd(2'd3, s);
        chk("R1 status", s, 0);
        chk("R1 irq", DW'(irq), 0);
        chk("R1 mem_we", DW'(mem_we), 0);
        chk("R1 dev_ready", DW'(dev_ready), 0);
        chk("R1 cpu_gnt", DW'(cpu_bus_gnt), 0);
    endtask

    task automatic t_regs();
        logic [DW-1:0] s;
        wr(2'd0, 32'h5A); rd(2'd0, s); chk("R2 addr readback", s, 32'h5A);
        wr(2'd1, 32'h7);  rd(2'd1, s); chk("R2 count readback", s, 32'h7);
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h2);  rd(2'd2, s); chk("R2 ctrl readback", s, 32'h2);
        wr(2'd2, 32'h0);  rd(2'd3, s); chk("R2 status idle", s, 0);
    endtask

    task automatic t_basic();
        logic [DW-1:0] s;
        int b0 = dev_idx;
        int w0 = nwr;
        mem_lat = 0; dev_gappy = 0;
        wr(2'd0, 32'h10); wr(2'd1, 32'd4);
        dev_arm(8);
        wr(2'd2, 32'h3);
        rd(2'd3, s); chk("R3 busy after start", s, 32'h4);
        wait_idle();
        for (int i = 0; i < 4; i++) chk("R3 word data", mem[8'h10 + i], 32'hC0DE_0000 + b0 + i);
        chk("R3 one write per word", nwr - w0, 4);
        chk("R5 no extra device word", dev_idx - b0, 4);
        rd(2'd3, s); chk("R5 done set", s, 32'h1);
        rd(2'd0, s); chk("R4 addr advanced", s, 32'h14);
        rd(2'd1, s); chk("R4 count zero", s, 0);
        chk("R7 irq on done", DW'(irq), 1);
        wr(2'd3, 32'h2); rd(2'd3, s); chk("R8 zero bit keeps done", s, 32'h1);
        wr(2'd3, 32'h1); rd(2'd3, s); chk("R8 done cleared", s, 0);
        chk("R8 irq cleared", DW'(irq), 0);
        dev_limit = dev_idx;
    endtask

    task automatic t_wrap();
        logic [DW-1:0] s;
        int b0 = dev_idx;
        mem_lat = 2; dev_gappy = 1;
        wr(2'd0, 32'hFE); wr(2'd1, 32'd3);
        dev_arm(3);
        wr(2'd2, 32'h1);
        wait_idle();
        chk("R4 wrap word FE", mem[8'hFE], 32'hC0DE_0000 + b0);
        chk("R4 wrap word FF", mem[8'hFF], 32'hC0DE_0000 + b0 + 1);
        chk("R4 wrap word 00", mem[8'h00], 32'hC0DE_0000 + b0 + 2);
        rd(2'd0, s); chk("R4 addr wrapped", s, 32'h01);
        rd(2'd3, s); chk("R5 done after wrap", s, 32'h1);
        chk("R7 irq off when disabled", DW'(irq), 0);
        wr(2'd3, 32'h1);
    endtask

    task automatic t_zero();
        logic [DW-1:0] s;
        int b0 = dev_idx;
        int w0 = nwr;
        int r0 = 0;
        wr(2'd1, 32'd0);
        dev_arm(4);
        wr(2'd2, 32'h3);
        rd(2'd3, s); chk("R6 error on zero count", s, 32'h2);
        chk("R7 irq on error", DW'(irq), 1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (mem_we || dev_ready) r0++;
        end
        chk("R6 no bus or device activity", DW'(r0), 0);
        chk("R6 no writes", nwr - w0, 0);
        chk("R6 no device words", dev_idx - b0, 0);
        wr(2'd3, 32'h2); rd(2'd3, s); chk("R8 error cleared", s, 0);
        chk("R8 irq dropped", DW'(irq), 0);
        dev_limit = dev_idx;
    endtask

    task automatic t_err();
        logic [DW-1:0] s;
        int b0 = dev_idx;
        mem_lat = 1; dev_gappy = 0;
        err_at = ack_idx + 2;
        mem[8'h42] = 32'hDEAD_BEEF;
        wr(2'd0, 32'h40); wr(2'd1, 32'd5);
        dev_arm(5);
        wr(2'd2, 32'h3);
        wait_idle();
        rd(2'd3, s); chk("R10 error status", s, 32'h2);
        rd(2'd0, s); chk("R10 addr at failed word", s, 32'h42);
        rd(2'd1, s); chk("R10 count at failed word", s, 32'h3);
        chk("R10 earlier word kept", mem[8'h41], 32'hC0DE_0000 + b0 + 1);
        chk("R10 failed word not stored", mem[8'h42], 32'hDEAD_BEEF);
        chk("R10 transfer stopped", dev_idx - b0, 3);
        chk("R7 irq on write error", DW'(irq), 1);
        err_at = -1;
        wr(2'd3, 32'h3);
        dev_limit = dev_idx;
    endtask

    task automatic t_busy_prio();
        logic [DW-1:0] s;
        int b0 = dev_idx;
        int w0 = nwr;
        int held = 0;
        logic [AW-1:0] ha = '0;
        logic [DW-1:0] hd = '0;
        bit prev = 0;
        mem_lat = 3; dev_gappy = 1;
        prio_bad = 0;
        cpu_bus_req = 1'b1;
        wr(2'd0, 32'h80); wr(2'd1, 32'd6);
        dev_arm(6);
        wr(2'd2, 32'h1);
        wr(2'd0, 32'h00);
        wr(2'd1, 32'h1);
        wr(2'd2, 32'h1);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            #1;
            if (prev && mem_we && (mem_addr !== ha || mem_wdata !== hd)) held++;
            prev = mem_we && !mem_ack;
            ha = mem_addr; hd = mem_wdata;
            if (!mem_we && !dev_ready && nwr - w0 >= 6) break;
        end
        wait_idle();
        chk("R12 write held during stall", DW'(held), 0);
        chk("R11 writes ignored while busy", nwr - w0, 6);
        chk("R11 first word at 80", mem[8'h80], 32'hC0DE_0000 + b0);
        chk("R11 last word at 85", mem[8'h85], 32'hC0DE_0000 + b0 + 5);
        rd(2'd0, s); chk("R11 addr end", s, 32'h86);
        chk("R9 cpu never granted with engine", DW'(prio_bad), 0);
        @(negedge clk);
        chk("R9 cpu granted when idle", DW'(cpu_bus_gnt), 1);
        cpu_bus_req = 1'b0;
        #1;
        chk("R9 no grant without request", DW'(cpu_bus_gnt), 0);
        wr(2'd3, 32'h3);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_basic();
        t_wrap();
        t_zero();
        t_err();
        t_busy_prio();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule